// File: doc/BRIEF.md
# Multiply Divide Accumulate Unit

This block is a small arithmetic engine that sits behind a register port. Software picks an operation by writing a control byte, loads two operand registers and then reads a result register. One datapath serves six operations: 16x16 multiply (unsigned or signed), 16x16 multiply-accumulate into a 32-bit accumulator (unsigned or signed), and 32-bit unsigned division. Division runs as a multi-cycle sequence and can optionally raise a completion pulse.

Multiply and accumulate complete on the same clock edge that accepts the write to the second operand register. A division is started by setting the start bit of the control byte in a divide mode. That bit then reads as a busy flag until the sequencer clears it. The accumulate path keeps a sticky overflow flag and a sign flag, which appear both on pins and in the control byte.

Top module: `muldiv_acc_unit`

## Requirements
- R1: After reset the control byte reads 0x00 (unsigned multiply), and `acc_ovf`, `acc_sign` and `div_irq` are 0.
- R2: Control byte layout: bit 7 is divide select, bit 6 is accumulate select, bit 3 is signed select, bit 2 is overflow, bit 1 is sign, bit 0 is start/busy. Bits 5 and 4 and bits 31..8 always read 0. Writes to bits 2 and 1 have no effect.
- R3: The mode code {bit7,bit6,bit3} may be 000, 001, 010, 011, 100 or 110. A control write that carries code 101 or 111 is dropped whole, and the previous control state stays.
- R4: In modes 000 and 001, a write to operand B (address 2) loads the result register (address 3) with the product of operand A bits 15..0 and the written bits 15..0. Mode 000 multiplies them as unsigned values and mode 001 as two's complement values. The product is readable after that one edge. Upper operand bits are ignored.
- R5: In mode 010, each write to operand B adds the unsigned product to the result register, modulo 2^32. Overflow sets when the true sum exceeds 0xFFFFFFFF.
- R6: In mode 011, each write to operand B adds the signed product to the result register. Overflow sets when two operands of the same sign give a sum of the opposite sign.
- R7: Overflow is sticky. Only a write to the result register, or an accepted control write that changes the mode code, clears it.
- R8: `acc_sign` equals result bit 31 in mode 011 and is 0 in every other mode.
- R9: In a divide mode, writing the control byte with bit 0 set divides operand A (address 1) by operand B. Bit 0 reads 1 for exactly 33 cycles. On the edge that clears it, the quotient appears at address 3 and the remainder at address 4.
- R10: Division by zero gives quotient 0xFFFFFFFF and a remainder equal to the dividend.
- R11: `div_irq` is a one-cycle pulse, in the cycle busy first reads 0. It occurs only for mode 100, never for mode 110.
- R12: While busy, every register write is ignored. A start bit written in a non-divide mode does not start anything. Address 4 and addresses 5..7 are not writable, and addresses 5..7 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address (0 control, 1 operand A, 2 operand B, 3 result, 4 remainder) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read address, same map |
| rd_data | output | 32 | Combinational read data |
| div_irq | output | 1 | One-cycle division completion pulse |
| acc_ovf | output | 1 | Sticky accumulate overflow flag |
| acc_sign | output | 1 | Accumulator sign flag |

## Verification
Multiply and accumulate results, and flag changes, are due one edge after the write that causes them. The bench drives each write on a falling edge and reads the result on the next falling edge. A division result and the clearing of busy are due 33 edges after the start write, and the completion pulse follows in the cycle after that last edge. The bench therefore counts busy readings one falling edge at a time and samples the pulse where busy first reads 0. A behavioural model advances on each rising edge, and the bench compares the flags and the pulse against it on every falling edge.

// File: rtl/mdau_pkg.sv
package mdau_pkg;
  localparam logic [2:0] MODE_MUL_U   = 3'b000;
  localparam logic [2:0] MODE_MUL_S   = 3'b001;
  localparam logic [2:0] MODE_MAC_U   = 3'b010;
  localparam logic [2:0] MODE_MAC_S   = 3'b011;
  localparam logic [2:0] MODE_DIV_IRQ = 3'b100;
  localparam logic [2:0] MODE_DIV_QT  = 3'b110;

  localparam logic [2:0] ADR_CTRL = 3'd0;
  localparam logic [2:0] ADR_OPA  = 3'd1;
  localparam logic [2:0] ADR_OPB  = 3'd2;
  localparam logic [2:0] ADR_RES  = 3'd3;
  localparam logic [2:0] ADR_REM  = 3'd4;

  function automatic logic mode_legal(input logic [2:0] code);
    return (code != 3'b101) && (code != 3'b111);
  endfunction

  function automatic logic mode_is_mac(input logic [2:0] code);
    return code[2:1] == 2'b01;
  endfunction

  function automatic logic mode_is_mul(input logic [2:0] code);
    return code[2:1] == 2'b00;
  endfunction
endpackage

// File: rtl/mdau_mac.sv
module mdau_mac #(
  parameter int OPW = 16
) (
  input  logic [OPW-1:0]   op_a,
  input  logic [OPW-1:0]   op_b,
  input  logic [2*OPW-1:0] acc,
  input  logic             is_signed,
  output logic [2*OPW-1:0] product,
  output logic [2*OPW-1:0] sum,
  output logic             ovf_evt
);
  localparam int PW = 2 * OPW;

  function automatic logic [PW-1:0] widen(input logic [OPW-1:0] v, input logic sg);
    return sg ? {{OPW{v[OPW-1]}}, v} : {{OPW{1'b0}}, v};
  endfunction

  function automatic logic unsigned_carry(input logic [PW:0] wide);
    return wide[PW];
  endfunction

  function automatic logic signed_wrap(input logic [PW-1:0] x, input logic [PW-1:0] y,
                                       input logic [PW-1:0] s);
    return (x[PW-1] == y[PW-1]) && (s[PW-1] != x[PW-1]);
  endfunction

  logic [PW:0] sum_wide;

  always_comb begin
    product  = widen(op_a, is_signed) * widen(op_b, is_signed);
    sum_wide = {1'b0, acc} + {1'b0, product};
    sum      = sum_wide[PW-1:0];
    ovf_evt  = is_signed ? signed_wrap(acc, product, sum) : unsigned_carry(sum_wide);
  end
endmodule

// File: rtl/mdau_divider.sv
module mdau_divider #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] dividend,
  input  logic [DW-1:0] divisor,
  output logic          busy,
  output logic          fin,
  output logic [DW-1:0] quot,
  output logic [DW-1:0] rem
);
  localparam int CW = $clog2(DW + 1);

  logic [CW-1:0] cnt_q;
  logic [DW-1:0] quot_q, rem_q, dvs_q;
  logic          busy_q;
  logic [DW:0]   shifted, trial;
  logic          fits;

  always_comb begin
    shifted = {rem_q, quot_q[DW-1]};
    trial   = shifted - {1'b0, dvs_q};
    fits    = shifted >= {1'b0, dvs_q};
  end

  assign fin  = busy_q && (cnt_q == CW'(DW));
  assign busy = busy_q;
  assign quot = quot_q;
  assign rem  = rem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      quot_q <= '0;
      rem_q  <= '0;
      dvs_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      quot_q <= dividend;
      rem_q  <= '0;
      dvs_q  <= divisor;
    end else if (fin) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      rem_q  <= fits ? trial[DW-1:0] : shifted[DW-1:0];
      quot_q <= {quot_q[DW-2:0], fits};
      cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/muldiv_acc_unit.sv
module muldiv_acc_unit
  import mdau_pkg::*;
#(
  parameter int OPW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [2:0]           wr_addr,
  input  logic [2*OPW-1:0]     wr_data,
  input  logic [2:0]           rd_addr,
  output logic [2*OPW-1:0]     rd_data,
  output logic                 div_irq,
  output logic                 acc_ovf,
  output logic                 acc_sign
);
  localparam int DW = 2 * OPW;

  logic [2:0]    mode_q;
  logic          ovf_q, irq_q, irq_en_q;
  logic [DW-1:0] opa_q, opb_q, res_q, rem_q;

  logic          div_busy, div_fin;
  logic [DW-1:0] div_quot, div_rem;
  logic [DW-1:0] mac_product, mac_sum;
  logic          mac_ovf_evt;

  // named events, also observed by the checker
  logic       wr_ok, ctrl_take, div_start, mac_step, mul_load, res_wr;
  logic       ovf_clr, ovf_set, sign_flag;
  logic [2:0] new_mode;
  logic [7:0] ctrl_byte;

  always_comb begin
    wr_ok     = wr_en && !div_busy;
    new_mode  = {wr_data[7], wr_data[6], wr_data[3]};
    ctrl_take = wr_ok && (wr_addr == ADR_CTRL) && mode_legal(new_mode);
    div_start = ctrl_take && new_mode[2] && wr_data[0];
    mac_step  = wr_ok && (wr_addr == ADR_OPB) && mode_is_mac(mode_q);
    mul_load  = wr_ok && (wr_addr == ADR_OPB) && mode_is_mul(mode_q);
    res_wr    = wr_ok && (wr_addr == ADR_RES);
    ovf_clr   = res_wr || (ctrl_take && (new_mode != mode_q));
    ovf_set   = mac_step && mac_ovf_evt;
    sign_flag = (mode_q == MODE_MAC_S) && res_q[DW-1];
    ctrl_byte = {mode_q[2], mode_q[1], 2'b00, mode_q[0], ovf_q, sign_flag, div_busy};
  end

  mdau_mac #(.OPW(OPW)) u_mac (
    .op_a      (opa_q[OPW-1:0]),
    .op_b      (wr_data[OPW-1:0]),
    .acc       (res_q),
    .is_signed (mode_q[0]),
    .product   (mac_product),
    .sum       (mac_sum),
    .ovf_evt   (mac_ovf_evt)
  );

  mdau_divider #(.DW(DW)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (div_start),
    .dividend (opa_q),
    .divisor  (opb_q),
    .busy     (div_busy),
    .fin      (div_fin),
    .quot     (div_quot),
    .rem      (div_rem)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MODE_MUL_U;
      ovf_q    <= 1'b0;
      irq_q    <= 1'b0;
      irq_en_q <= 1'b0;
      opa_q    <= '0;
      opb_q    <= '0;
      res_q    <= '0;
      rem_q    <= '0;
    end else begin
      irq_q <= div_fin && irq_en_q;
      if (ctrl_take) mode_q <= new_mode;
      if (div_start) irq_en_q <= (new_mode == MODE_DIV_IRQ);
      if (wr_ok && (wr_addr == ADR_OPA)) opa_q <= wr_data;
      if (wr_ok && (wr_addr == ADR_OPB)) opb_q <= wr_data;
      if (res_wr)        res_q <= wr_data;
      else if (mul_load) res_q <= mac_product;
      else if (mac_step) res_q <= mac_sum;
      else if (div_fin)  res_q <= div_quot;
      if (div_fin) rem_q <= div_rem;
      if (ovf_clr)      ovf_q <= 1'b0;
      else if (ovf_set) ovf_q <= 1'b1;
    end
  end

  always_comb begin
    case (rd_addr)
      ADR_CTRL: rd_data = {{(DW-8){1'b0}}, ctrl_byte};
      ADR_OPA:  rd_data = opa_q;
      ADR_OPB:  rd_data = opb_q;
      ADR_RES:  rd_data = res_q;
      ADR_REM:  rd_data = rem_q;
      default:  rd_data = '0;
    endcase
  end

  assign div_irq  = irq_q;
  assign acc_ovf  = ovf_q;
  assign acc_sign = sign_flag;
endmodule

// File: rtl/mdau_checker.sv
module mdau_checker
  import mdau_pkg::*;
#(
  parameter int STEPS = 32
) (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mode,
  input logic       busy,
  input logic       fin,
  input logic       irq,
  input logic       ovf,
  input logic       ovf_clr,
  input logic       sign
);
  localparam int BW = $clog2(STEPS + 2);
  logic [BW-1:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 1'b1;
    else           busy_cnt <= '0;
  end

  p_legal_mode_r3: assert property (@(posedge clk) disable iff (!rst_n) mode_legal(mode));
  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n) ovf && !ovf_clr |=> ovf);
  p_ovf_clear_r7: assert property (@(posedge clk) disable iff (!rst_n) ovf_clr |=> !ovf);
  p_sign_mode_r8: assert property (@(posedge clk) disable iff (!rst_n) (mode != MODE_MAC_S) |-> !sign);
  p_busy_len_r9: assert property (@(posedge clk) disable iff (!rst_n) fin |-> (busy_cnt == BW'(STEPS)));
  p_fin_clears_r9: assert property (@(posedge clk) disable iff (!rst_n) fin |=> !busy);
  p_irq_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n) irq |=> !irq);
  p_irq_mode_r11: assert property (@(posedge clk) disable iff (!rst_n) irq |-> (mode == MODE_DIV_IRQ));
  p_irq_after_fin_r11: assert property (@(posedge clk) disable iff (!rst_n) irq |-> $past(fin));
endmodule

bind muldiv_acc_unit mdau_checker #(.STEPS(2 * OPW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .mode    (mode_q),
  .busy    (div_busy),
  .fin     (div_fin),
  .irq     (div_irq),
  .ovf     (acc_ovf),
  .ovf_clr (ovf_clr),
  .sign    (acc_sign)
);

// File: tb/muldiv_acc_unit_bench.sv
`timescale 1ns/1ps
module muldiv_acc_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        div_irq, acc_ovf, acc_sign;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  muldiv_acc_unit u_muldiv_acc_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .div_irq(div_irq), .acc_ovf(acc_ovf),
    .acc_sign(acc_sign)
  );

  // behavioural reference model
  logic [2:0]  m_mode;
  bit          m_ovf, m_busy, m_irq, m_en;
  logic [31:0] m_a, m_b, m_res, m_rem, m_q, m_r;
  int          m_left;

  function automatic longint prod(bit sg, logic [31:0] a, logic [31:0] b);
    if (sg) return longint'(shortint'(a[15:0])) * longint'(shortint'(b[15:0]));
    return longint'(a[15:0]) * longint'(b[15:0]);
  endfunction

  function automatic bit m_sign();
    return (m_mode == 3'b011) && m_res[31];
  endfunction

  function automatic logic [31:0] m_ctrl();
    return {24'd0, m_mode[2], m_mode[1], 2'b00, m_mode[0], m_ovf, m_sign(), m_busy};
  endfunction

  task automatic model_write(logic [2:0] adr, logic [31:0] d);
    logic [2:0] code;
    longint p, s;
    case (adr)
      3'd0: begin
        code = {d[7], d[6], d[3]};
        if (code != 3'b101 && code != 3'b111) begin
          if (code != m_mode) m_ovf = 0;
          m_mode = code;
          if (code[2] && d[0]) begin
            if (m_b == 0) begin m_q = 32'hFFFF_FFFF; m_r = m_a; end
            else begin m_q = m_a / m_b; m_r = m_a % m_b; end
            m_busy = 1; m_left = 33; m_en = (code == 3'b100);
          end
        end
      end
      3'd1: m_a = d;
      3'd2: begin
        m_b = d;
        p = prod(m_mode[0], m_a, d);
        if (m_mode[2:1] == 2'b00) m_res = p[31:0];
        else if (m_mode == 3'b010) begin
          s = longint'(m_res) + p;
          if (s > 64'sh0FFFF_FFFF) m_ovf = 1;
          m_res = s[31:0];
        end else if (m_mode == 3'b011) begin
          s = longint'(int'(m_res)) + p;
          if (s > 64'sd2147483647 || s < -64'sd2147483648) m_ovf = 1;
          m_res = s[31:0];
        end
      end
      3'd3: begin m_res = d; m_ovf = 0; end
      default: ;
    endcase
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_ovf = 0; m_busy = 0; m_irq = 0; m_en = 0;
      m_a = 0; m_b = 0; m_res = 0; m_rem = 0; m_q = 0; m_r = 0; m_left = 0;
    end else begin
      m_irq = 0;
      if (m_busy) begin
        m_left--;
        if (m_left == 0) begin
          m_busy = 0; m_res = m_q; m_rem = m_r; m_irq = m_en;
        end
      end else if (wr_en) model_write(wr_addr, wr_data);
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // per-cycle comparison of the flag and pulse pins (R7, R8, R11)
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R7 acc_ovf pin", {31'd0, acc_ovf}, {31'd0, m_ovf});
      chk("R8 acc_sign pin", {31'd0, acc_sign}, {31'd0, m_sign()});
      chk("R11 div_irq pin", {31'd0, div_irq}, {31'd0, m_irq});
    end
  end

  task automatic wr(logic [2:0] adr, logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = adr; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(logic [2:0] adr, logic [31:0] exp, string tag);
    rd_addr = adr;
    #0.5;
    chk(tag, rd_data, exp);
  endtask

  task automatic div_run(bit exp_irq, string tag);
    int busy_cycles = 0;
    for (int k = 0; k < 60; k++) begin
      rd_addr = 3'd0;
      #0.5;
      if (!rd_data[0]) break;
      busy_cycles++;
      @(negedge clk);
    end
    chk({tag, " R9 busy length"}, busy_cycles, 33);
    chk({tag, " R11 pulse at completion"}, {31'd0, div_irq}, {31'd0, exp_irq});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(3'd0, 32'h0, "R1 ctrl after reset");
    chk("R1 flags after reset", {29'd0, acc_ovf, acc_sign, div_irq}, 32'd0);
    // R2 read-only and reserved bits
    wr(3'd0, 32'hFFFF_FF36);
    rd(3'd0, 32'h0, "R2 reserved and flag bits ignored");
    rd(3'd5, 32'h0, "R12 unused address reads 0");
    // R3 illegal codes dropped
    wr(3'd0, 32'h0000_0048);
    wr(3'd0, 32'h0000_0088);
    rd(3'd0, 32'h48, "R3 code 101 dropped");
    wr(3'd0, 32'h0000_00C9);
    rd(3'd0, 32'h48, "R3 code 111 dropped");
    // R4 unsigned multiply
    wr(3'd0, 32'h0);
    wr(3'd1, 32'h1234_FFFF);
    wr(3'd2, 32'h5678_FFFF);
    rd(3'd3, 32'hFFFE_0001, "R4 unsigned product");
    wr(3'd0, 32'h1);
    rd(3'd0, 32'h0, "R12 start ignored outside divide");
    // R4 signed multiply
    wr(3'd0, 32'h08);
    wr(3'd2, 32'h0000_0002);
    rd(3'd3, 32'hFFFF_FFFE, "R4 signed product");
    wr(3'd1, 32'hABCD_0003);
    wr(3'd2, 32'h9999_FFFB);
    rd(3'd3, 32'hFFFF_FFF1, "R4 signed upper bits ignored");
    // R5 unsigned accumulate with overflow
    wr(3'd0, 32'h40);
    wr(3'd3, 32'hF000_0000);
    wr(3'd1, 32'h0000_FFFF);
    wr(3'd2, 32'h0000_FFFF);
    rd(3'd3, 32'hEFFE_0001, "R5 unsigned wrap sum");
    rd(3'd0, 32'h44, "R5 overflow bit in ctrl");
    wr(3'd1, 32'h1);
    wr(3'd2, 32'h1);
    rd(3'd3, 32'hEFFE_0002, "R5 next step");
    chk("R7 overflow held", {31'd0, acc_ovf}, 32'd1);
    wr(3'd0, 32'h40);
    chk("R7 same mode keeps overflow", {31'd0, acc_ovf}, 32'd1);
    wr(3'd3, 32'h0);
    chk("R7 result write clears", {31'd0, acc_ovf}, 32'd0);
    // R6 signed accumulate
    wr(3'd0, 32'h48);
    wr(3'd3, 32'h7FFF_0000);
    wr(3'd1, 32'h7FFF);
    wr(3'd2, 32'h7FFF);
    rd(3'd3, 32'hBFFE_0001, "R6 positive overflow sum");
    rd(3'd0, 32'h4E, "R6 R8 ovf and sign in ctrl");
    wr(3'd0, 32'h40);
    rd(3'd0, 32'h40, "R7 mode change clears, R8 sign 0 unsigned");
    wr(3'd0, 32'h48);
    wr(3'd3, 32'h8000_0000);
    wr(3'd1, 32'hFFFF);
    wr(3'd2, 32'h0001);
    rd(3'd3, 32'h7FFF_FFFF, "R6 negative overflow sum");
    chk("R6 negative overflow flag", {31'd0, acc_ovf}, 32'd1);
    wr(3'd3, 32'd10);
    wr(3'd2, 32'd5);
    rd(3'd3, 32'd5, "R6 no overflow on mixed signs");
    chk("R6 flag stays clear", {31'd0, acc_ovf}, 32'd0);
    // R9, R11 division with pulse
    wr(3'd1, 32'd1000);
    wr(3'd0, 32'h80);
    wr(3'd2, 32'd7);
    wr(3'd0, 32'h81);
    div_run(1'b1, "div 1000/7");
    rd(3'd3, 32'd142, "R9 quotient");
    rd(3'd4, 32'd6, "R9 remainder");
    rd(3'd0, 32'h80, "R9 busy cleared, mode kept");
    // R11 quiet division, large operands
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd2, 32'h0001_0000);
    wr(3'd0, 32'hC1);
    div_run(1'b0, "div quiet");
    rd(3'd3, 32'h0000_FFFF, "R9 large quotient");
    rd(3'd4, 32'h0000_FFFF, "R9 large remainder");
    // R10 divide by zero
    wr(3'd1, 32'h1234_5678);
    wr(3'd2, 32'h0);
    wr(3'd0, 32'h81);
    div_run(1'b1, "div by zero");
    rd(3'd3, 32'hFFFF_FFFF, "R10 quotient all ones");
    rd(3'd4, 32'h1234_5678, "R10 remainder is dividend");
    // R12 writes ignored while busy
    wr(3'd1, 32'd100);
    wr(3'd2, 32'd9);
    wr(3'd0, 32'h81);
    wr(3'd1, 32'd5);
    wr(3'd0, 32'h00);
    wr(3'd4, 32'hDEAD_BEEF);
    repeat (40) @(negedge clk);
    rd(3'd3, 32'd11, "R12 quotient from old operands");
    rd(3'd4, 32'd1, "R12 remainder from old operands");
    rd(3'd1, 32'd100, "R12 operand write dropped while busy");
    rd(3'd0, 32'h80, "R12 control write dropped while busy");
    wr(3'd4, 32'hDEAD_BEEF);
    rd(3'd4, 32'd1, "R12 remainder not writable");
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule